// File: doc/BRIEF.md
# Delayed Synaptic Accumulation Unit

This unit sits between spike arrival and neuron update in a spiking-network core. Each incoming event names an input axon and can carry a signed graded value. A fan-out table maps that axon to a run of synapse entries. Each entry holds a signed weight, a left-shift exponent, a target neuron and a delay in timesteps. The unit walks the run at one synapse per clock. For each synapse it forms weight times event value, shifted left by the exponent, and adds the result with saturation into the accumulator that belongs to the target neuron and to the timestep the delay selects.

The accumulators form a ring with one slot per reachable timestep. A barrier pulse ends the current timestep. The unit then presents every neuron's sum from the current slot as one registered vector, clears that slot in the same edge, and moves the ring head forward by one slot. If a barrier arrives while a fan-out walk is still running, it is held back until the walk finishes. Both tables are loaded through a simple write-only configuration port.

Top module: `dsa_accum_unit`

## Requirements
- R1: After reset, busy and step_valid are low, every fan-out count is zero so an event produces no work, and every accumulator slot reads zero.
- R2: A configuration write with cfg_sel=0 loads the fan-out entry of axon cfg_addr: base synapse address in cfg_data[4:0], synapse count in cfg_data[21:16]. A write with cfg_sel=1 loads synapse entry cfg_addr: weight in cfg_data[15:0], delay in [21:16], shift in [24:22], target neuron in [31:28].
- R3: A binary event (ev_graded=0) contributes weight shifted left by the shift field. A graded event contributes weight times the signed ev_payload, shifted left by the shift field.
- R4: With cfg_wide=1 the full 16-bit weight is used. With cfg_wide=0 only bits [7:0] are used, as a signed 8-bit value.
- R5: A contribution with delay d appears in the step_sums presented by the (d+1)-th barrier after the event is accepted. Delay codes above 62 are treated as 62.
- R6: Accumulation saturates at +8388607 and -8388608 and never wraps.
- R7: An accepted event with count N holds busy high for exactly N cycles and handles one synapse per cycle. ev_valid is ignored while busy is high.
- R8: A barrier that arrives while synapses are still being processed is deferred: busy stays high and the readout is taken only after the walk ends. step_valid rises in the cycle after the barrier takes effect, together with the sums of the slot being closed.
- R9: An event accepted in the same cycle as a barrier belongs to the new timestep. Its delay-0 contributions appear at the next barrier, not the concurrent one.
- R10: The slot that is read out is cleared in the same edge, so a following barrier with no new events presents zero for that slot.
- R11: The ring head advances modulo 63 slots on each barrier, so slots are reused after 63 timesteps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the fan-out table, 1 selects the synapse table |
| cfg_addr | input | 8 | Table entry index |
| cfg_data | input | 32 | Entry contents |
| cfg_wide | input | 1 | 1 selects 16-bit weights, 0 selects 8-bit weights |
| ev_valid | input | 1 | Spike event present |
| ev_axon | input | 4 | Input axon index |
| ev_graded | input | 1 | 1 means ev_payload carries the event value |
| ev_payload | input | 16 | Signed graded value |
| step_pulse | input | 1 | Timestep barrier pulse |
| busy | output | 1 | A fan-out walk or a deferred barrier is outstanding |
| step_valid | output | 1 | One-cycle pulse marking valid step_sums |
| step_sums | output | 192 | Signed 24-bit sum per neuron; neuron n sits at bits [24n+23:24n] |

## Verification
A wrong ring head or a slot that is not cleared does not show at the ports until the affected slot is read out. Depending on the delay, that can be up to 63 barriers later, so the bench runs a maximum-delay contribution through a full turn of the ring. Errors in the fan-out walk show within a few cycles: busy has the wrong length, or a single barrier shows missing or doubled sums. Arithmetic faults in weight selection, shifting or saturation show at the very next barrier, at the neuron that was targeted.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  localparam int ACC_W = 24;
  localparam int WGT_W = 16;
  localparam int PAY_W = 16;
  localparam int SHF_W = 3;
  localparam int DLY_W = 6;
  localparam int NID_W = 4;
  localparam int CFG_W = 32;
  localparam int PRD_W = WGT_W + PAY_W;
  localparam int CTB_W = PRD_W + (1 << SHF_W);
  localparam int SUM_W = CTB_W + 1;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [WGT_W-1:0] wgt_t;
  typedef logic signed [PAY_W-1:0] pay_t;
  typedef logic signed [CTB_W-1:0] ctb_t;

  typedef struct packed {
    logic [NID_W-1:0] neuron;
    logic [SHF_W-1:0] shift;
    logic [DLY_W-1:0] delay;
    logic [WGT_W-1:0] weight;
  } syn_t;

  localparam acc_t ACC_HI = {1'b0, {(ACC_W-1){1'b1}}};
  localparam acc_t ACC_LO = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] SAT_HI = {{(SUM_W-ACC_W){1'b0}}, ACC_HI};
  localparam logic signed [SUM_W-1:0] SAT_LO = {{(SUM_W-ACC_W){1'b1}}, ACC_LO};

  // Weight width mode: narrow mode keeps the low byte as a signed value.
  function automatic wgt_t pick_weight(input logic [WGT_W-1:0] raw, input logic wide);
    if (wide) return wgt_t'(raw);
    return wgt_t'({{(WGT_W-8){raw[7]}}, raw[7:0]});
  endfunction

  // Weight times event value, then a power-of-two scale by arithmetic shift.
  function automatic ctb_t scale_contrib(input wgt_t w, input pay_t v,
                                         input logic [SHF_W-1:0] sh);
    logic signed [PRD_W-1:0] prod;
    ctb_t ext;
    prod = $signed({{PAY_W{w[WGT_W-1]}}, w}) * $signed({{WGT_W{v[PAY_W-1]}}, v});
    ext  = {{(CTB_W-PRD_W){prod[PRD_W-1]}}, prod};
    return ext <<< sh;
  endfunction

  // Saturating accumulate into the signed 24-bit range.
  function automatic acc_t sat_add(input acc_t a, input ctb_t c);
    logic signed [SUM_W-1:0] s;
    s = $signed({{(SUM_W-ACC_W){a[ACC_W-1]}}, a}) + $signed({c[CTB_W-1], c});
    if (s > SAT_HI) return ACC_HI;
    if (s < SAT_LO) return ACC_LO;
    return s[ACC_W-1:0];
  endfunction

  // Ring slot for a delay, with out-of-range delays pinned to the maximum.
  function automatic int ring_slot(input int head, input int dly, input int max_dly);
    int d;
    int s;
    d = (dly > max_dly) ? max_dly : dly;
    s = head + d;
    if (s > max_dly) s = s - (max_dly + 1);
    return s;
  endfunction
endpackage

// File: rtl/dsa_fanout_table.sv
module dsa_fanout_table
  import dsa_pkg::*;
#(
  parameter int NUM_AXONS = 16,
  parameter int NUM_SYN   = 32,
  localparam int AX_AW  = $clog2(NUM_AXONS),
  localparam int SYN_AW = $clog2(NUM_SYN),
  localparam int CNT_W  = $clog2(NUM_SYN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AX_AW-1:0]  wr_axon,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [AX_AW-1:0]  rd_axon,
  output logic [SYN_AW-1:0] rd_base,
  output logic [CNT_W-1:0]  rd_count
);
  logic [SYN_AW-1:0] base_q  [NUM_AXONS];
  logic [CNT_W-1:0]  count_q [NUM_AXONS];

  for (genvar a = 0; a < NUM_AXONS; a++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[a]  <= '0;
        count_q[a] <= '0;
      end else if (wr_en && (wr_axon == AX_AW'(a))) begin
        base_q[a]  <= wr_data[SYN_AW-1:0];
        count_q[a] <= wr_data[16 +: CNT_W];
      end
    end
  end

  assign rd_base  = base_q[rd_axon];
  assign rd_count = count_q[rd_axon];
endmodule

// File: rtl/dsa_syn_mem.sv
module dsa_syn_mem
  import dsa_pkg::*;
#(
  parameter int NUM_SYN = 32,
  localparam int SYN_AW = $clog2(NUM_SYN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SYN_AW-1:0] wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [SYN_AW-1:0] rd_addr,
  output syn_t              rd_entry
);
  syn_t mem_q [NUM_SYN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SYN; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr].weight <= wr_data[15:0];
      mem_q[wr_addr].delay  <= wr_data[21:16];
      mem_q[wr_addr].shift  <= wr_data[24:22];
      mem_q[wr_addr].neuron <= wr_data[31:28];
    end
  end

  assign rd_entry = mem_q[rd_addr];
endmodule

// File: rtl/dsa_seq.sv
module dsa_seq
  import dsa_pkg::*;
#(
  parameter int NUM_AXONS = 16,
  parameter int NUM_SYN   = 32,
  localparam int SYN_AW = $clog2(NUM_SYN),
  localparam int CNT_W  = $clog2(NUM_SYN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_graded,
  input  pay_t              ev_payload,
  input  logic              step_pulse,
  input  logic [SYN_AW-1:0] fan_base,
  input  logic [CNT_W-1:0]  fan_count,
  output logic [SYN_AW-1:0] syn_ptr,
  output pay_t              ev_value,
  output logic              syn_fire,
  output logic              step_commit,
  output logic              busy
);
  logic             active_q;
  logic             pend_q;
  logic [CNT_W-1:0] remain_q;
  logic             ev_accept;

  // A barrier takes effect only once no synapse walk is in flight.
  assign step_commit = (step_pulse || pend_q) && !active_q;
  assign ev_accept   = ev_valid && !active_q && !pend_q;
  assign busy        = active_q || pend_q;
  assign syn_fire    = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      remain_q <= '0;
      syn_ptr  <= '0;
      ev_value <= '0;
    end else begin
      pend_q <= (step_pulse || pend_q) && !step_commit;
      if (ev_accept) begin
        syn_ptr  <= fan_base;
        remain_q <= fan_count;
        active_q <= (fan_count != '0);
        ev_value <= ev_graded ? ev_payload : pay_t'(1);
      end else if (active_q) begin
        syn_ptr  <= syn_ptr + 1'b1;
        remain_q <= remain_q - 1'b1;
        if (remain_q == CNT_W'(1)) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsa_ring.sv
module dsa_ring
  import dsa_pkg::*;
#(
  parameter int NUM_NEURONS = 8,
  parameter int MAX_DELAY   = 62,
  localparam int RING   = MAX_DELAY + 1,
  localparam int HEAD_W = $clog2(RING),
  localparam int NEU_AW = $clog2(NUM_NEURONS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           add_en,
  input  logic [DLY_W-1:0]               add_delay,
  input  logic [NID_W-1:0]               add_neuron,
  input  ctb_t                           add_val,
  input  logic                           step_commit,
  output logic [HEAD_W-1:0]              head,
  output logic                           step_valid,
  output logic [NUM_NEURONS*ACC_W-1:0]   step_sums
);
  acc_t              ring_q [RING][NUM_NEURONS];
  acc_t              sums_q [NUM_NEURONS];
  logic [HEAD_W-1:0] add_slot;
  logic              add_ok;
  logic [NEU_AW-1:0] nidx;

  assign add_slot = HEAD_W'(ring_slot(int'(head), int'(add_delay), MAX_DELAY));
  assign add_ok   = add_en && (int'(add_neuron) < NUM_NEURONS);
  assign nidx     = add_neuron[NEU_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head       <= '0;
      step_valid <= 1'b0;
      for (int s = 0; s < RING; s++)
        for (int n = 0; n < NUM_NEURONS; n++) ring_q[s][n] <= '0;
      for (int n = 0; n < NUM_NEURONS; n++) sums_q[n] <= '0;
    end else begin
      step_valid <= step_commit;
      if (step_commit) begin
        for (int n = 0; n < NUM_NEURONS; n++) begin
          sums_q[n]       <= ring_q[head][n];
          ring_q[head][n] <= '0;
        end
        head <= (head == HEAD_W'(RING-1)) ? '0 : head + 1'b1;
      end else if (add_ok) begin
        ring_q[add_slot][nidx] <= sat_add(ring_q[add_slot][nidx], add_val);
      end
    end
  end

  for (genvar n = 0; n < NUM_NEURONS; n++) begin : g_out
    assign step_sums[n*ACC_W +: ACC_W] = sums_q[n];
  end
endmodule

// File: rtl/dsa_accum_unit.sv
module dsa_accum_unit
  import dsa_pkg::*;
#(
  parameter int NUM_AXONS   = 16,
  parameter int NUM_NEURONS = 8,
  parameter int NUM_SYN     = 32,
  parameter int MAX_DELAY   = 62,
  parameter int CFG_AW      = 8,
  localparam int AX_AW  = $clog2(NUM_AXONS),
  localparam int SYN_AW = $clog2(NUM_SYN),
  localparam int CNT_W  = $clog2(NUM_SYN + 1),
  localparam int HEAD_W = $clog2(MAX_DELAY + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic                         cfg_sel,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [CFG_W-1:0]             cfg_data,
  input  logic                         cfg_wide,
  input  logic                         ev_valid,
  input  logic [AX_AW-1:0]             ev_axon,
  input  logic                         ev_graded,
  input  logic [PAY_W-1:0]             ev_payload,
  input  logic                         step_pulse,
  output logic                         busy,
  output logic                         step_valid,
  output logic [NUM_NEURONS*ACC_W-1:0] step_sums
);
  logic [SYN_AW-1:0] fan_base;
  logic [CNT_W-1:0]  fan_count;
  logic [SYN_AW-1:0] syn_ptr;
  pay_t              ev_value;
  logic              syn_fire;
  logic              step_commit;
  logic [HEAD_W-1:0] head;
  syn_t              syn_entry;
  wgt_t              eff_weight;
  ctb_t              contrib;

  dsa_fanout_table #(.NUM_AXONS(NUM_AXONS), .NUM_SYN(NUM_SYN)) u_fanout (
    .clk, .rst_n,
    .wr_en(cfg_we && !cfg_sel), .wr_axon(cfg_addr[AX_AW-1:0]), .wr_data(cfg_data),
    .rd_axon(ev_axon), .rd_base(fan_base), .rd_count(fan_count)
  );

  dsa_syn_mem #(.NUM_SYN(NUM_SYN)) u_synmem (
    .clk, .rst_n,
    .wr_en(cfg_we && cfg_sel), .wr_addr(cfg_addr[SYN_AW-1:0]), .wr_data(cfg_data),
    .rd_addr(syn_ptr), .rd_entry(syn_entry)
  );

  dsa_seq #(.NUM_AXONS(NUM_AXONS), .NUM_SYN(NUM_SYN)) u_seq (
    .clk, .rst_n, .ev_valid, .ev_graded, .ev_payload(pay_t'(ev_payload)), .step_pulse,
    .fan_base, .fan_count, .syn_ptr, .ev_value, .syn_fire, .step_commit, .busy
  );

  assign eff_weight = pick_weight(syn_entry.weight, cfg_wide);
  assign contrib    = scale_contrib(eff_weight, ev_value, syn_entry.shift);

  dsa_ring #(.NUM_NEURONS(NUM_NEURONS), .MAX_DELAY(MAX_DELAY)) u_ring (
    .clk, .rst_n,
    .add_en(syn_fire), .add_delay(syn_entry.delay), .add_neuron(syn_entry.neuron),
    .add_val(contrib), .step_commit, .head, .step_valid, .step_sums
  );
endmodule

// File: rtl/dsa_accum_checker.sv
module dsa_accum_checker #(
  parameter int MAX_DELAY = 62,
  localparam int RING   = MAX_DELAY + 1,
  localparam int HEAD_W = $clog2(RING)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              step_pulse,
  input logic              busy,
  input logic              step_valid,
  input logic              syn_fire,
  input logic              step_commit,
  input logic [HEAD_W-1:0] head
);
  assert_head_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    step_commit |=> head == (($past(head) == HEAD_W'(RING-1)) ? '0 : $past(head) + 1'b1));

  assert_hold_head_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_commit |=> $stable(head));

  assert_deferred_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && syn_fire) |=> (busy && !step_valid));

  assert_readout_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_commit |=> step_valid);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({syn_fire, step_commit}));

  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_valid || step_pulse));
endmodule

bind dsa_accum_unit dsa_accum_checker #(.MAX_DELAY(MAX_DELAY)) i_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .step_pulse(step_pulse),
  .busy(busy), .step_valid(step_valid), .syn_fire(syn_fire),
  .step_commit(step_commit), .head(head)
);

// File: tb/test_dsa_accum_unit.sv
`timescale 1ns/1ps
module test_dsa_accum_unit;
  localparam int NN = 8;
  localparam int SW = NN * 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_wide = 1'b1;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic ev_valid = 1'b0, ev_graded = 1'b0, step_pulse = 1'b0;
  logic [3:0] ev_axon = '0;
  logic [15:0] ev_payload = '0;
  logic busy, step_valid;
  logic [SW-1:0] step_sums;

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  dsa_accum_unit i_dsa_accum_unit (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_addr, .cfg_data, .cfg_wide,
    .ev_valid, .ev_axon, .ev_graded, .ev_payload, .step_pulse,
    .busy, .step_valid, .step_sums
  );

  typedef struct packed {
    logic        wide;
    logic [15:0] wgt;
    logic [2:0]  shf;
    logic        graded;
    logic [15:0] pay;
    logic [23:0] expv;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 16'd100,   3'd0, 1'b0, 16'd0,     24'd100},
    '{1'b1, 16'hFFFD,  3'd2, 1'b0, 16'd0,     -24'sd12},
    '{1'b0, 16'h01FF,  3'd0, 1'b0, 16'd0,     -24'sd1},
    '{1'b1, 16'h01FF,  3'd0, 1'b0, 16'd0,     24'd511},
    '{1'b1, 16'd7,     3'd1, 1'b1, 16'hFFFB,  -24'sd70},
    '{1'b0, 16'h0080,  3'd3, 1'b1, 16'd2,     -24'sd2048},
    '{1'b1, 16'h7FFF,  3'd7, 1'b1, 16'h7FFF,  24'h7FFFFF},
    '{1'b1, 16'h8000,  3'd7, 1'b1, 16'h7FFF,  24'h800000},
    '{1'b1, 16'd1000,  3'd0, 1'b1, 16'd0,     24'd0}
  };

  task automatic chk(input string req, input longint act, input longint expv);
    n_checks++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint nsum(input logic [SW-1:0] v, input int n);
    return longint'($signed(v[n*24 +: 24]));
  endfunction

  task automatic cfg_fan(input int ax, input int base, input int cnt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = 8'(ax);
    cfg_data = {10'b0, 6'(cnt), 11'b0, 5'(base)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_syn(input int addr, input int neu, input int dly, input int sh,
                         input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_addr = 8'(addr);
    cfg_data = {4'(neu), 3'b000, 3'(sh), 6'(dly), w};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  task automatic send_event(input int ax, input logic gr, input logic [15:0] pay);
    @(negedge clk);
    drain();
    ev_valid = 1'b1; ev_axon = 4'(ax); ev_graded = gr; ev_payload = pay;
    @(negedge clk);
    ev_valid = 1'b0;
    drain();
  endtask

  task automatic do_step(output logic [SW-1:0] s);
    @(negedge clk);
    step_pulse = 1'b1;
    @(negedge clk);
    step_pulse = 1'b0;
    for (int k = 0; k < 200 && !step_valid; k++) @(negedge clk);
    s = step_sums;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [SW-1:0] s;
    int busy_cycles;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state at the ports
    chk("R1 busy after reset", longint'(busy), 0);
    chk("R1 step_valid after reset", longint'(step_valid), 0);
    ev_valid = 1'b1; ev_axon = 4'd4;
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R1 unconfigured axon leaves busy low", longint'(busy), 0);
    do_step(s);
    bad = 0;
    for (int n = 0; n < NN; n++) if (nsum(s, n) != 0) bad++;
    chk("R1 empty slot sums", bad, 0);

    // R2 R3 R4 R6: table of single-synapse vectors on axon 0, neuron 0, delay 0
    cfg_fan(0, 0, 1);
    for (int i = 0; i < 9; i++) begin
      cfg_wide = VEC[i].wide;
      cfg_syn(0, 0, 0, int'(VEC[i].shf), VEC[i].wgt);
      send_event(0, VEC[i].graded, VEC[i].pay);
      do_step(s);
      chk($sformatf("R3/R4/R6 vector %0d", i), nsum(s, 0), longint'($signed(VEC[i].expv)));
    end
    cfg_wide = 1'b1;

    // R6: saturated sum stays at the limit over two events
    cfg_syn(0, 1, 0, 7, 16'h7FFF);
    send_event(0, 1'b1, 16'h7FFF);
    send_event(0, 1'b1, 16'h7FFF);
    do_step(s);
    chk("R6 repeated positive saturation", nsum(s, 1), 8388607);

    // R7: three synapses, busy length, ignored event while busy
    cfg_syn(20, 0, 0, 0, 16'd1);
    cfg_syn(21, 1, 0, 0, 16'd2);
    cfg_syn(22, 2, 0, 0, 16'd3);
    cfg_fan(2, 20, 3);
    @(negedge clk);
    ev_valid = 1'b1; ev_axon = 4'd2; ev_graded = 1'b0;
    @(negedge clk);
    busy_cycles = 0;
    for (int k = 0; k < 20; k++) begin
      if (busy) busy_cycles++;
      if (k == 1) ev_valid = 1'b0;
      @(negedge clk);
    end
    chk("R7 busy length equals count", busy_cycles, 3);
    do_step(s);
    chk("R7 neuron0 not doubled", nsum(s, 0), 1);
    chk("R7 neuron1", nsum(s, 1), 2);
    chk("R7 neuron2", nsum(s, 2), 3);

    // R10: slot cleared at readout
    do_step(s);
    chk("R10 cleared slot neuron2", nsum(s, 2), 0);

    // R8: barrier during a walk is deferred
    @(negedge clk);
    ev_valid = 1'b1; ev_axon = 4'd2; ev_graded = 1'b0;
    @(negedge clk);
    ev_valid = 1'b0; step_pulse = 1'b1;
    @(negedge clk);
    step_pulse = 1'b0;
    chk("R8 busy held while deferred", longint'(busy), 1);
    chk("R8 no early readout", longint'(step_valid), 0);
    for (int k = 0; k < 50 && !step_valid; k++) @(negedge clk);
    chk("R8 deferred readout arrives", longint'(step_valid), 1);
    chk("R8 deferred readout includes event", nsum(step_sums, 2), 3);

    // R9: event with concurrent barrier lands in the new timestep
    @(negedge clk);
    ev_valid = 1'b1; ev_axon = 4'd2; step_pulse = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0; step_pulse = 1'b0;
    chk("R9 concurrent barrier readout valid", longint'(step_valid), 1);
    chk("R9 concurrent event not in closing step", nsum(step_sums, 1), 0);
    drain();
    do_step(s);
    chk("R9 event in following step", nsum(s, 1), 2);

    // R5: delay 3 lands at the fourth barrier
    cfg_syn(10, 2, 3, 0, 16'd5);
    cfg_fan(1, 10, 1);
    send_event(1, 1'b0, 16'd0);
    do_step(s);
    chk("R5 delay3 absent at step1", nsum(s, 2), 0);
    do_step(s);
    do_step(s);
    chk("R5 delay3 absent at step3", nsum(s, 2), 0);
    do_step(s);
    chk("R5 delay3 present at step4", nsum(s, 2), 5);

    // R5 R11: delay code 63 acts as 62 and the ring wraps
    cfg_syn(12, 5, 63, 0, 16'd9);
    cfg_fan(3, 12, 1);
    send_event(3, 1'b0, 16'd0);
    bad = 0;
    for (int k = 0; k < 62; k++) begin
      do_step(s);
      if (nsum(s, 5) != 0) bad++;
    end
    chk("R5 clamped delay silent for 62 steps", bad, 0);
    do_step(s);
    chk("R5 R11 clamped delay at step 63 after wrap", nsum(s, 5), 9);
    do_step(s);
    chk("R11 reused slot starts clean", nsum(s, 5), 0);

    finish_run();
  end
endmodule